// File: doc/BRIEF.md
# Vectored Interrupt Requester with Acknowledge Daisy Chain

This block is the interrupt side of a plug-in module on a shared backplane. An internal event, either a rising edge on a front-panel trigger input or an event counter reaching a programmed preset, marks a request as pending. While a request is pending, the block pulls one of seven active-low request lines low. Software chooses that line by writing a level number.

An interrupt handler services the request with an acknowledge cycle. The acknowledge enters the block on a daisy-chain input and carries the level being serviced on three address bits. If the block has a pending request at exactly that level, it returns its programmed 8-bit vector and strobes a data acknowledge. In every other case it forwards the acknowledge to the next slot on its daisy-chain output. Servicing does not end the request. Only a software write to the clear register drops it. An event that arrives while a request is already pending does not queue a second request. It raises a sticky overflow flag instead.

Top module: `irq_chain_node`

## Requirements
- R1: After reset, all seven request lines, the daisy-chain output and the data acknowledge are high; vector valid, pending and overflow are low; the level, vector and preset registers hold zero.
- R2: A rising edge on `trig_in` sets pending at the next clock edge. While pending, bit `level-1` of `irq_n` is low and every other bit is high. Level 0 drives no request line.
- R3: Each `cnt_tick` advances an internal count. The tick that brings the count to the preset value is an event, and the count restarts from zero. A preset of 0 disables the counter. Writing the preset also zeroes the count.
- R4: In the cycle after `iack_in_n` falls with `ack_lvl` equal to a nonzero level and a request pending, `vec_valid` is 1, `vec_data` holds the vector register, `ack_n` is 0 and `iack_out_n` stays high. All of these are held until the cycle after `iack_in_n` rises.
- R5: In the cycle after `iack_in_n` falls without such a match, `iack_out_n` goes low, and it rises in the cycle after `iack_in_n` rises. The respond-or-pass decision is taken when the acknowledge begins and is kept for the whole acknowledge cycle. `vec_data` reads zero when it is not valid.
- R6: A pending request survives any number of acknowledge cycles. A write to address 3 clears pending and overflow whatever the data, and it leaves the other registers unchanged.
- R7: An event while pending sets `overflow` and changes nothing else. An event in the same cycle as a clear write leaves pending set and overflow clear.
- R8: The write map is: address 0 holds the level in `wr_data[2:0]`, address 1 holds the vector in `wr_data[7:0]`, and address 2 holds the preset in `wr_data[CNT_W-1:0]`. Writes take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Front-panel event input, rising edge counts |
| cnt_tick | input | 1 | Count pulse for the preset counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | DATA_W | Write data |
| ack_lvl | input | 3 | Level being acknowledged (address bits 3..1) |
| iack_in_n | input | 1 | Daisy-chain acknowledge in, active low |
| irq_n | output | 7 | Request lines, bit i is level i+1, active low |
| iack_out_n | output | 1 | Daisy-chain acknowledge out, active low |
| vec_data | output | 8 | Vector returned in the acknowledge cycle |
| vec_valid | output | 1 | Vector is being driven |
| ack_n | output | 1 | Data acknowledge for the status/ID read, active low |
| pending | output | 1 | Request pending |
| overflow | output | 1 | Event arrived while already pending |

## Verification
A pending bit that is wrong shows up on `irq_n` in the very next cycle. It also changes the respond-or-pass choice of the next acknowledge. A corrupted acknowledge state shows as a vector and a forwarded acknowledge present together, or as an acknowledge held after `iack_in_n` has risen. Both are visible one cycle later. A counter that is off by one moves the cycle in which pending rises, and a lost overflow shows as soon as the second event lands. The bench therefore compares every output against its model on every clock, which locates any divergence to a single cycle.

// File: rtl/irq_chain_node.sv
module irq_chain_node #(
  parameter int LEVELS = 7,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in,
  input  logic              cnt_tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        ack_lvl,
  input  logic              iack_in_n,
  output logic [LEVELS-1:0] irq_n,
  output logic              iack_out_n,
  output logic [7:0]        vec_data,
  output logic              vec_valid,
  output logic              ack_n,
  output logic              pending,
  output logic              overflow
);
  localparam int LW = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_RESP, ST_PASS} ack_st_t;

  logic [LW-1:0]    level_q;
  logic [7:0]       vec_q;
  logic [CNT_W-1:0] preset_q, cnt_q, cnt_nxt;
  logic             pend_q, ovf_q, trig_q;
  ack_st_t          st_q;

  wire wr_lvl = wr_en && (wr_addr == 2'd0);
  wire wr_vec = wr_en && (wr_addr == 2'd1);
  wire wr_pre = wr_en && (wr_addr == 2'd2);
  wire wr_clr = wr_en && (wr_addr == 2'd3);

  assign cnt_nxt = cnt_q + 1'b1;
  wire cnt_on  = cnt_tick && (preset_q != '0);
  wire cnt_hit = cnt_on && (cnt_nxt == preset_q);
  wire trig_ev = trig_in && !trig_q;
  wire event_p = trig_ev || cnt_hit;
  wire match   = pend_q && (level_q != '0) && (ack_lvl == level_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q  <= '0;
      vec_q    <= '0;
      preset_q <= '0;
    end else begin
      if (wr_lvl) level_q  <= wr_data[LW-1:0];
      if (wr_vec) vec_q    <= wr_data[7:0];
      if (wr_pre) preset_q <= wr_data[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= trig_in;
      if (wr_pre)      cnt_q <= '0;
      else if (cnt_on) cnt_q <= cnt_hit ? '0 : cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (event_p)     pend_q <= 1'b1;
      else if (wr_clr) pend_q <= 1'b0;
      if (wr_clr)                 ovf_q <= 1'b0;
      else if (event_p && pend_q) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else begin
      case (st_q)
        ST_IDLE: if (!iack_in_n) st_q <= match ? ST_RESP : ST_PASS;
        default: if (iack_in_n)  st_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < LEVELS; i++) begin : g_req
    assign irq_n[i] = !(pend_q && (level_q == LW'(i + 1)));
  end

  assign iack_out_n = (st_q != ST_PASS);
  assign vec_valid  = (st_q == ST_RESP);
  assign ack_n      = !vec_valid;
  assign vec_data   = vec_valid ? vec_q : 8'h00;
  assign pending    = pend_q;
  assign overflow   = ovf_q;

  p_one_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~irq_n));

  p_line_needs_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |-> (&irq_n));

  p_resp_or_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_valid && !iack_out_n));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iack_in_n |=> (iack_out_n && !vec_valid));

  p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!iack_in_n && iack_out_n && !vec_valid && !match) |=> !iack_out_n);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !wr_clr) |=> pending);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(pending));
endmodule

// File: tb/test_irq_chain_node.sv
module test_irq_chain_node;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int DATA_W = 16;

  logic clk = 0, rst_n = 0;
  logic trig_in = 0, cnt_tick = 0, wr_en = 0, iack_in_n = 1;
  logic [1:0] wr_addr = 0;
  logic [DATA_W-1:0] wr_data = 0;
  logic [2:0] ack_lvl = 0;
  logic [6:0] irq_n;
  logic iack_out_n, vec_valid, ack_n, pending, overflow;
  logic [7:0] vec_data;

  int checks = 0, errors = 0;
  bit cmp_on = 0, done = 0;

  int m_level, m_vec, m_preset, m_cnt, m_st;
  bit m_pend, m_ovf, m_trig_q;

  irq_chain_node #(.LEVELS(7), .CNT_W(CNT_W), .DATA_W(DATA_W)) i_irq_chain_node (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .cnt_tick(cnt_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ack_lvl(ack_lvl),
    .iack_in_n(iack_in_n), .irq_n(irq_n), .iack_out_n(iack_out_n),
    .vec_data(vec_data), .vec_valid(vec_valid), .ack_n(ack_n),
    .pending(pending), .overflow(overflow));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_level = 0; m_vec = 0; m_preset = 0; m_cnt = 0; m_st = 0;
      m_pend = 0; m_ovf = 0; m_trig_q = 0;
    end else begin
      bit hit, ev, clr, match;
      hit = cnt_tick && m_preset != 0 && (m_cnt + 1 == m_preset);
      ev = (trig_in && !m_trig_q) || hit;
      clr = wr_en && wr_addr == 3;
      match = m_pend && m_level != 0 && ack_lvl == m_level;
      if (m_st == 0 && !iack_in_n) m_st = match ? 1 : 2;
      else if (m_st != 0 && iack_in_n) m_st = 0;
      if (clr) m_ovf = 0; else if (ev && m_pend) m_ovf = 1;
      if (ev) m_pend = 1; else if (clr) m_pend = 0;
      if (wr_en && wr_addr == 2) m_cnt = 0;
      else if (cnt_tick && m_preset != 0) m_cnt = hit ? 0 : m_cnt + 1;
      if (wr_en && wr_addr == 0) m_level = wr_data[2:0];
      if (wr_en && wr_addr == 1) m_vec = wr_data[7:0];
      if (wr_en && wr_addr == 2) m_preset = wr_data;
      m_trig_q = trig_in;
    end
  end

  // every-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      int e_irq;
      e_irq = 7'h7f;
      if (m_pend && m_level != 0) e_irq = e_irq & ~(1 << (m_level - 1));
      chk("R2 irq_n", irq_n, e_irq);
      chk("R5 iack_out_n", iack_out_n, m_st != 2);
      chk("R4 vec_valid", vec_valid, m_st == 1);
      chk("R4 ack_n", ack_n, m_st != 1);
      chk("R4 vec_data", vec_data, (m_st == 1) ? m_vec : 0);
      chk("R6 pending", pending, m_pend);
      chk("R7 overflow", overflow, m_ovf);
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = a[1:0]; wr_data = d[DATA_W-1:0];
    tick();
    wr_en = 0; wr_data = 0;
  endtask

  task automatic trig();
    trig_in = 1; tick(); trig_in = 0; tick();
  endtask

  task automatic ack_begin(int lvl);
    ack_lvl = lvl[2:0]; iack_in_n = 0; tick();
  endtask

  task automatic ack_end();
    iack_in_n = 1; tick();
  endtask

  initial begin
    repeat (3) tick();
    // R1 reset state
    chk("R1 irq_n", irq_n, 7'h7f);
    chk("R1 iack_out_n", iack_out_n, 1);
    chk("R1 vec_valid", vec_valid, 0);
    chk("R1 ack_n", ack_n, 1);
    chk("R1 pending", pending, 0);
    chk("R1 overflow", overflow, 0);
    rst_n = 1;
    tick();
    cmp_on = 1;

    // R8 registers, R2 trigger
    wr(0, 3); wr(1, 16'hFFA5);
    trig();
    chk("R2 pending", pending, 1);
    chk("R2 line", irq_n, 7'b1111011);

    // R4 respond, R6 persists
    ack_begin(3);
    chk("R4 vec", vec_data, 8'hA5);
    chk("R4 chain held", iack_out_n, 1);
    repeat (2) tick();
    chk("R4 held", vec_valid, 1);
    ack_end();
    chk("R4 released", vec_valid, 0);
    chk("R6 still pending", pending, 1);

    // R7 overflow
    trig();
    chk("R7 overflow", overflow, 1);
    chk("R7 single line", irq_n, 7'b1111011);

    // R5 pass at other level
    ack_begin(5);
    chk("R5 passed", iack_out_n, 0);
    chk("R5 no vector", vec_valid, 0);
    ack_end();
    chk("R5 pass released", iack_out_n, 1);

    // R6 clear with arbitrary data
    wr(3, 16'hFFFF);
    chk("R6 cleared", pending, 0);
    chk("R6 ovf cleared", overflow, 0);
    trig();
    chk("R6 level kept", irq_n, 7'b1111011);
    wr(3, 0);

    // R5 decision latched during cycle
    ack_begin(3);
    chk("R5 idle pass", iack_out_n, 0);
    trig();
    chk("R5 decision kept", iack_out_n, 0);
    chk("R5 decision kept vec", vec_valid, 0);
    ack_end();
    ack_begin(3);
    chk("R4 new cycle responds", vec_valid, 1);
    ack_end();
    wr(3, 0);

    // R3 counter
    wr(2, 4);
    repeat (3) begin cnt_tick = 1; tick(); end
    chk("R3 not yet", pending, 0);
    tick();
    cnt_tick = 0;
    chk("R3 preset reached", pending, 1);
    wr(3, 0);
    cnt_tick = 1; repeat (3) tick(); cnt_tick = 0;
    chk("R3 count restarted", pending, 0);
    cnt_tick = 1; tick(); cnt_tick = 0;
    chk("R3 second hit", pending, 1);
    wr(3, 0);
    wr(2, 0);
    cnt_tick = 1; repeat (10) tick(); cnt_tick = 0;
    chk("R3 disabled", pending, 0);

    // R2 level 0 drives nothing, ack passes
    wr(0, 0);
    trig();
    chk("R2 level0 no line", irq_n, 7'h7f);
    ack_begin(0);
    chk("R5 level0 pass", iack_out_n, 0);
    ack_end();
    wr(0, 7);
    chk("R2 level7 line", irq_n, 7'b0111111);

    // R7 event coinciding with clear
    trig();
    chk("R7 ovf set", overflow, 1);
    wr_en = 1; wr_addr = 3; trig_in = 1; tick();
    wr_en = 0; trig_in = 0;
    chk("R7 pend after coincident", pending, 1);
    chk("R7 ovf after coincident", overflow, 0);
    tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule